// File: doc/BRIEF.md
# PCIe Inbound BAR Decoder and Address Translator

This block sits on the receive side of a PCIe endpoint, after header parsing. It takes the address of an inbound memory request and finds the base address register window that the address falls in. There are up to six windows, and two neighbouring slots can be joined into one 64-bit window. The block then raises one select line that steers the request to the local bus master serving that window. It also hands that master the offset inside the window as a local byte address. Bits above the window size are used only for matching, and bits below it pass through unchanged.

Configuration comes in as static inputs: per-slot enables, 32-bit base register values, log2 window sizes, and one "64-bit pair" flag for each even/odd pair of slots. In root-port operation no decoding takes place, and every request goes to master 0 with its full address. Results are registered, so they appear one cycle after the request strobe. They stay unchanged while no request is presented.

Top module: `bar_xlate_top`

## Requirements
- R1: A request hits an enabled slot when all address bits at and above the slot's window size equal the same bits of its base; a 32-bit slot has base bits 63:32 equal to zero, so it only matches addresses below 4 GiB.
- R2: On a hit, `local_addr_o` equals the request address with every bit at and above the window size cleared (the address modulo the window size); base bits below the window size, such as flag bits, have no effect.
- R3: When `bar_pair64_i[k]` is 1, slot 2k decodes a 64-bit base {slot 2k+1 register, slot 2k register}, a hit raises `bar_sel_o[2k]`, and slot 2k+1 never matches on its own.
- R4: Each slot's size is a 6-bit log2 byte count in `bar_log2_i[6s+5:6s]`; values below 7 act as 7 (128 bytes).
- R5: When several slots match, only the lowest-numbered one is selected.
- R6: When no enabled slot matches in endpoint mode, `miss_o` is 1, `hit_o` is 0, `bar_sel_o` is all zero and `local_addr_o` is zero.
- R7: When `root_mode_i` is 1, every request gives `hit_o`=1, `miss_o`=0, `bar_sel_o`=1 (master 0 only) and `local_addr_o` equal to the whole (extended) request address.
- R8: When `req_is32_i` is 1, bits 63:32 of `req_addr_i` are ignored and treated as zero.
- R9: Results appear on the outputs at the clock edge that samples `req_valid_i`=1, with `out_valid_o` high for that one cycle; while `req_valid_i` is 0 the decision outputs keep their values.
- R10: After reset, all outputs are zero.
- R11: A slot whose `bar_en_i` bit is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| root_mode_i | input | 1 | 1: root-port bypass, all requests to master 0 |
| req_valid_i | input | 1 | Request address strobe |
| req_addr_i | input | 64 | Request byte address |
| req_is32_i | input | 1 | Request carried a 32-bit address |
| bar_en_i | input | NUM_BARS | Per-slot enable |
| bar_pair64_i | input | NUM_BARS/2 | Bit k joins slots 2k and 2k+1 into one 64-bit window |
| bar_base_i | input | 32*NUM_BARS | Base register of slot s at bits 32s+31:32s |
| bar_log2_i | input | 6*NUM_BARS | Log2 window size of slot s at bits 6s+5:6s |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| hit_o | output | 1 | Request matched a window (or root mode) |
| miss_o | output | 1 | Request matched no window |
| bar_sel_o | output | NUM_BARS | One-hot master select |
| local_addr_o | output | 64 | Offset inside the selected window |

## Verification
Two functions land in the same cycle when one address lies inside two windows at once. In the bench configuration, a 1 MiB window at slot 2 sits inside a 16 MiB window at slot 4. The bench probes both edges of the small window, so the priority choice and the offset width of the chosen window must agree in a single result. A second collision comes from a 32-bit request whose upper address bits carry junk that would land in the paired 64-bit window. Zero-extension must win before the match is made. For every probe, the expected select and offset are computed from range arithmetic (address minus aligned base, compared with the size) rather than from bit masks.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned ADDR_W   = 2 * REG_W;
    localparam int unsigned LOG2_W   = 6;
    localparam int unsigned MIN_LOG2 = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LOG2_W-1:0] log2_t;

    typedef struct packed {
        logic  hit;
        logic  miss;
        addr_t local_addr;
    } xlate_res_t;

    // Mask of the bits that take part in matching (at and above window size).
    function automatic addr_t match_mask(input log2_t lg);
        log2_t eff;
        eff = (lg < log2_t'(MIN_LOG2)) ? log2_t'(MIN_LOG2) : lg;
        return ~((addr_t'(1) << eff) - addr_t'(1));
    endfunction

    function automatic addr_t extend_addr(input addr_t a, input logic is32);
        return is32 ? {{REG_W{1'b0}}, a[REG_W-1:0]} : a;
    endfunction

endpackage

// File: rtl/bar_base_merge.sv
module bar_base_merge
    import bar_xlate_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6
) (
    input  logic [NUM_BARS*REG_W-1:0]    base_flat_i,
    input  logic [NUM_BARS-1:0]          en_i,
    input  logic [NUM_BARS/2-1:0]        pair64_i,
    output addr_t [NUM_BARS-1:0]         eff_base_o,
    output logic  [NUM_BARS-1:0]         eff_en_o
);

    localparam addr_t ZERO_HI = '0;

    for (genvar s = 0; s < NUM_BARS; s++) begin : g_slot
        if (s % 2 == 0) begin : g_even
            if (s + 1 < NUM_BARS) begin : g_pair
                assign eff_base_o[s] = pair64_i[s/2]
                    ? {base_flat_i[(s+1)*REG_W +: REG_W], base_flat_i[s*REG_W +: REG_W]}
                    : {ZERO_HI[REG_W-1:0], base_flat_i[s*REG_W +: REG_W]};
            end else begin : g_lone
                assign eff_base_o[s] = {ZERO_HI[REG_W-1:0], base_flat_i[s*REG_W +: REG_W]};
            end
            assign eff_en_o[s] = en_i[s];
        end else begin : g_odd
            // upper half of a 64-bit pair never decodes by itself (R3)
            assign eff_base_o[s] = {ZERO_HI[REG_W-1:0], base_flat_i[s*REG_W +: REG_W]};
            assign eff_en_o[s]   = en_i[s] & ~pair64_i[s/2];
        end
    end

endmodule

// File: rtl/bar_slot_decoder.sv
module bar_slot_decoder
    import bar_xlate_pkg::*;
(
    input  logic  enable_i,
    input  addr_t base_i,
    input  log2_t log2_i,
    input  addr_t addr_i,
    output logic  match_o,
    output addr_t offset_o
);

    addr_t hi_mask;

    always_comb begin
        hi_mask  = match_mask(log2_i);
        match_o  = enable_i && (((addr_i ^ base_i) & hi_mask) == '0);
        offset_o = addr_i & ~hi_mask;
    end

endmodule

// File: rtl/bar_prio_pick.sv
module bar_prio_pick #(
    parameter int unsigned N = 6
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] match_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);

    logic found;

    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match_i[i] && !found) begin
                pick_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
        any_o = found;
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(pick_o)); // R5
    AST_PICK_LOWEST: assert property (@(posedge clk_i) disable iff (rst_i)
        any_o |-> (((pick_o - 1'b1) & match_i) == '0) && ((pick_o & match_i) != '0)); // R5

endmodule

// File: rtl/bar_xlate_top.sv
module bar_xlate_top
    import bar_xlate_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         root_mode_i,
    input  logic                         req_valid_i,
    input  logic [ADDR_W-1:0]            req_addr_i,
    input  logic                         req_is32_i,
    input  logic [NUM_BARS-1:0]          bar_en_i,
    input  logic [NUM_BARS/2-1:0]        bar_pair64_i,
    input  logic [NUM_BARS*REG_W-1:0]    bar_base_i,
    input  logic [NUM_BARS*LOG2_W-1:0]   bar_log2_i,
    output logic                         out_valid_o,
    output logic                         hit_o,
    output logic                         miss_o,
    output logic [NUM_BARS-1:0]          bar_sel_o,
    output logic [ADDR_W-1:0]            local_addr_o
);

    addr_t                 ext_addr;
    addr_t [NUM_BARS-1:0]  eff_base;
    logic  [NUM_BARS-1:0]  eff_en;
    logic  [NUM_BARS-1:0]  slot_match;
    addr_t [NUM_BARS-1:0]  slot_off;
    logic  [NUM_BARS-1:0]  pick;
    logic                  any_hit;
    addr_t                 pick_off;
    xlate_res_t            res_d, res_q;
    logic  [NUM_BARS-1:0]  sel_d, sel_q;
    logic                  vld_q;

    assign ext_addr = extend_addr(req_addr_i, req_is32_i);

    bar_base_merge #(.NUM_BARS(NUM_BARS)) u_merge (
        .base_flat_i (bar_base_i),
        .en_i        (bar_en_i),
        .pair64_i    (bar_pair64_i),
        .eff_base_o  (eff_base),
        .eff_en_o    (eff_en)
    );

    for (genvar s = 0; s < NUM_BARS; s++) begin : g_dec
        bar_slot_decoder u_dec (
            .enable_i (eff_en[s]),
            .base_i   (eff_base[s]),
            .log2_i   (bar_log2_i[s*LOG2_W +: LOG2_W]),
            .addr_i   (ext_addr),
            .match_o  (slot_match[s]),
            .offset_o (slot_off[s])
        );
    end

    bar_prio_pick #(.N(NUM_BARS)) u_pick (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .match_i (slot_match),
        .pick_o  (pick),
        .any_o   (any_hit)
    );

    always_comb begin
        pick_off = '0;
        for (int s = 0; s < NUM_BARS; s++) begin
            if (pick[s]) pick_off = pick_off | slot_off[s];
        end
    end

    always_comb begin
        if (root_mode_i) begin
            res_d.hit        = 1'b1;
            res_d.miss       = 1'b0;
            res_d.local_addr = ext_addr;
            sel_d            = NUM_BARS'(1);
        end else begin
            res_d.hit        = any_hit;
            res_d.miss       = !any_hit;
            res_d.local_addr = pick_off;
            sel_d            = pick;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q <= '0;
            sel_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid_i;
            if (req_valid_i) begin
                res_q <= res_d;
                sel_q <= sel_d;
            end
        end
    end

    assign out_valid_o  = vld_q;
    assign hit_o        = res_q.hit;
    assign miss_o       = res_q.miss;
    assign bar_sel_o    = sel_q;
    assign local_addr_o = res_q.local_addr;

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> $stable(bar_sel_o) && $stable(local_addr_o)
                         && $stable(hit_o) && $stable(miss_o)); // R9
    AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hit_o && miss_o)); // R6
    AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        miss_o |-> (bar_sel_o == '0) && (local_addr_o == '0)); // R6
    AST_ROOT_SEL: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && root_mode_i) |=> hit_o && (bar_sel_o == NUM_BARS'(1))); // R7
    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(bar_sel_o) && (hit_o == (bar_sel_o != '0))); // R5

endmodule

// File: tb/bar_xlate_top_tb_top.sv
module bar_xlate_top_tb_top;

    localparam int NB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          root_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic [63:0]   req_addr  = '0;
    logic          req_is32  = 1'b0;
    logic [NB-1:0] cfg_en;
    logic [2:0]    cfg_pair;
    logic [31:0]   cfg_base [NB];
    logic [5:0]    cfg_lg   [NB];
    logic [NB*32-1:0] base_flat;
    logic [NB*6-1:0]  lg_flat;

    logic          out_valid, hit, miss;
    logic [NB-1:0] sel;
    logic [63:0]   loc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always_comb begin
        for (int s = 0; s < NB; s++) begin
            base_flat[s*32 +: 32] = cfg_base[s];
            lg_flat[s*6 +: 6]     = cfg_lg[s];
        end
    end

    bar_xlate_top #(.NUM_BARS(NB)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .root_mode_i  (root_mode),
        .req_valid_i  (req_valid),
        .req_addr_i   (req_addr),
        .req_is32_i   (req_is32),
        .bar_en_i     (cfg_en),
        .bar_pair64_i (cfg_pair),
        .bar_base_i   (base_flat),
        .bar_log2_i   (lg_flat),
        .out_valid_o  (out_valid),
        .hit_o        (hit),
        .miss_o       (miss),
        .bar_sel_o    (sel),
        .local_addr_o (loc)
    );

    // Range-arithmetic reference model.
    function automatic void model(input logic [63:0] a, input logic is32, input logic root,
                                  output logic h, output logic m,
                                  output logic [NB-1:0] es, output logic [63:0] el);
        logic [63:0] eff, base, size;
        int lg;
        bit found;
        eff = is32 ? {32'h0, a[31:0]} : a;
        h = 0; m = 0; es = '0; el = '0;
        if (root) begin
            h = 1; es = NB'(1); el = eff;
            return;
        end
        found = 0;
        for (int s = 0; s < NB; s++) begin
            if (found || !cfg_en[s]) continue;
            if ((s % 2 == 1) && cfg_pair[s/2]) continue;
            lg   = (cfg_lg[s] < 7) ? 7 : int'(cfg_lg[s]);
            size = 64'd1 << lg;
            if ((s % 2 == 0) && (s + 1 < NB) && cfg_pair[s/2])
                base = {cfg_base[s+1], cfg_base[s]};
            else
                base = {32'h0, cfg_base[s]};
            base = (base / size) * size;
            if (eff >= base && (eff - base) < size) begin
                h = 1; es[s] = 1'b1; el = eff - base; found = 1;
            end
        end
        m = !h;
    endfunction

    task automatic check(input string req, input logic [NB-1:0] xs, input logic [63:0] xl,
                         input logic xh, input logic xm, input logic xv);
        checks++;
        if (sel !== xs || loc !== xl || hit !== xh || miss !== xm || out_valid !== xv) begin
            errors++;
            $display("FAIL %s: got sel=%b loc=%h hit=%b miss=%b vld=%b exp sel=%b loc=%h hit=%b miss=%b vld=%b",
                     req, sel, loc, hit, miss, out_valid, xs, xl, xh, xm, xv);
        end
    endtask

    task automatic probe(input logic [63:0] a, input logic is32, input logic root, input string req);
        logic h, m;
        logic [NB-1:0] es;
        logic [63:0] el;
        model(a, is32, root, h, m, es, el);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is32 = is32; root_mode = root;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, es, el, h, m, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        // slots 1:0 joined, base 0x00001234_5678900C (flag bits low), 4 KiB
        cfg_base[0] = 32'h5678_900C; cfg_lg[0] = 6'd12;
        cfg_base[1] = 32'h0000_1234; cfg_lg[1] = 6'd12;
        cfg_base[2] = 32'h8000_0000; cfg_lg[2] = 6'd20;
        cfg_base[3] = 32'h9000_0000; cfg_lg[3] = 6'd16;
        cfg_base[4] = 32'h8000_0000; cfg_lg[4] = 6'd24;
        cfg_base[5] = 32'hC000_0040; cfg_lg[5] = 6'd3;
        cfg_en   = 6'b110111;
        cfg_pair = 3'b001;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", '0, '0, 1'b0, 1'b0, 1'b0);

        probe(64'h0000_1234_5678_9ABC, 1'b0, 1'b0, "R2");
        probe(64'h0000_1234_5678_9000, 1'b0, 1'b0, "R3");
        probe(64'h0000_1234_5678_9FFF, 1'b0, 1'b0, "R3");
        probe(64'h0000_1234_5678_A000, 1'b0, 1'b0, "R1");
        probe(64'h0000_0000_5678_9ABC, 1'b0, 1'b0, "R3");
        probe(64'h0000_0000_0000_1100, 1'b0, 1'b0, "R3");
        probe(64'h0000_0000_9000_0010, 1'b0, 1'b0, "R11");
        probe(64'h0000_0001_8000_0010, 1'b0, 1'b0, "R1");
        probe(64'h0000_0000_8000_0010, 1'b0, 1'b0, "R5");
        probe(64'h0000_0000_800F_FFFF, 1'b0, 1'b0, "R5");
        probe(64'h0000_0000_8010_0000, 1'b0, 1'b0, "R5");
        probe(64'h0000_0000_80FF_FFFF, 1'b0, 1'b0, "R2");
        probe(64'h0000_0000_8100_0000, 1'b0, 1'b0, "R6");
        probe(64'h0000_0000_C000_007F, 1'b0, 1'b0, "R4");
        probe(64'h0000_0000_C000_0080, 1'b0, 1'b0, "R4");
        probe(64'h0000_0000_BFFF_FFFF, 1'b0, 1'b0, "R6");
        probe(64'hDEAD_BEEF_8000_0010, 1'b1, 1'b0, "R8");
        probe(64'hDEAD_BEEF_8000_0010, 1'b0, 1'b0, "R8");
        probe(64'h0000_1234_5678_9ABC, 1'b1, 1'b0, "R8");
        probe(64'h0000_1234_5678_9ABC, 1'b0, 1'b1, "R7");
        probe(64'hFFFF_0000_1111_2222, 1'b1, 1'b1, "R7");

        // near-exhaustive sweep of every window's edges
        for (int s = 0; s < NB; s++) begin
            logic [63:0] b, sz;
            int lg;
            lg = (cfg_lg[s] < 7) ? 7 : int'(cfg_lg[s]);
            sz = 64'd1 << lg;
            b  = ((s % 2 == 0) && cfg_pair[s/2] && s + 1 < NB) ? {cfg_base[s+1], cfg_base[s]}
                                                                : {32'h0, cfg_base[s]};
            b  = (b / sz) * sz;
            probe(b - 64'd1,       1'b0, 1'b0, "R1");
            probe(b,               1'b0, 1'b0, "R1");
            probe(b + 64'd1,       1'b0, 1'b0, "R2");
            probe(b + (sz >> 1),   1'b0, 1'b0, "R2");
            probe(b + sz - 64'd1,  1'b0, 1'b0, "R2");
            probe(b + sz,          1'b0, 1'b0, "R1");
        end

        // pseudo-random addresses folded into the configured regions
        lfsr = 64'h1357_9BDF_2468_ACE1;
        for (int i = 0; i < 64; i++) begin
            logic [63:0] a;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            case (i % 4)
                0: a = {32'h0000_1234, 20'h56789, lfsr[11:0]} ^ {52'h0, lfsr[13:12] == 2'b11, 11'h0};
                1: a = {32'h0, 8'h80, lfsr[23:0]};
                2: a = {32'h0, 24'hC00000, lfsr[7:0]};
                default: a = lfsr;
            endcase
            probe(a, lfsr[40], 1'b0, "R1");
        end

        // hold while strobe is low (R9)
        probe(64'h0000_0000_8000_0ABC, 1'b0, 1'b0, "R9");
        @(negedge clk);
        req_addr = 64'h0000_0000_C000_0005; root_mode = 1'b1;
        @(negedge clk);
        check("R9", 6'b000100, 64'h0000_0000_0000_0ABC, 1'b1, 1'b0, 1'b0);
        root_mode = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule